// File: doc/BRIEF.md
# Serial Audio Word Formatter

This block converts between the raw bits of an audio slot and a 32-bit data word. It has one receive path and one transmit path, and both use the same configuration. The receive path takes the bits a serial slot shifter has assembled for one slot and builds the word that is then stored in a holding register. The transmit path takes a word the host has written into that register and builds the slot bits that the shifter sends out.

Two size codes set the shape of each word: the slot width and the sample (data) width. Four option controls then reshape it:
- where the sample sits inside the slot;
- whether the sample bits are mirrored;
- where the sample sits inside the 32-bit word;
- how the unused upper bits of a right-aligned word are filled.

For the same configuration, the transmit path undoes exactly what the receive path does. Each path is combinational and ends in an output register, so a result appears one clock after its input is valid.

Top module: `audio_fmt`

## Requirements
- R1: The size codes 0, 1, 2 and 3 on `slot_size_i` and `data_size_i` select 8, 16, 24 and 32 bits. If the data size code is larger than the slot size code, the effective sample width equals the slot width.
- R2: Receive, slot alignment. With `slot_left_i`=1 the sample is taken from the most significant sample-width bits of the slot, which sits in `rx_slot_i[slot_w-1:0]`. With `slot_left_i`=0 it is taken from the least significant bits. Bus bits at or above the slot width are ignored.
- R3: With `bit_rev_i`=1 the order of the sample-width bits is mirrored in both paths. Padding and fill bits are never mirrored.
- R4: Receive, `word_left_i`=1: the sample occupies `rx_word_o[31:32-dw]` and every lower bit is 0, whatever the extension mode.
- R5: Receive, `word_left_i`=0: the sample occupies `rx_word_o[dw-1:0]`. With `ext_mode_i`=0 every bit above it is 0.
- R6: Receive, `word_left_i`=0, `ext_mode_i`=1: every bit above the sample equals the sample's top bit, taken after any mirroring.
- R7: Receive, `word_left_i`=0: with `ext_mode_i`=2 every bit above the sample is 1. `ext_mode_i`=3 behaves like 0.
- R8: Transmit. The sample is taken from `tx_word_i[31:32-dw]` when `word_left_i`=1 and from `tx_word_i[dw-1:0]` otherwise; the other word bits are ignored. It is mirrored if `bit_rev_i`=1. It is then placed at the top of the slot (`slot_left_i`=1) or at the bottom. Every other bit of `tx_slot_o` is 0, including the bits above the slot width.
- R9: Under one configuration, a receive result fed back into the transmit path reproduces the original slot's sample bits at their original positions, with all other slot bits 0.
- R10: Each path registers its result one clock after its valid input is high and raises its valid output in that same cycle. While the valid input is low the data output holds. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_size_i | input | 2 | Slot width code (8/16/24/32) |
| data_size_i | input | 2 | Sample width code (8/16/24/32) |
| slot_left_i | input | 1 | 1: sample at top of slot, 0: at bottom |
| bit_rev_i | input | 1 | Mirror the sample bits |
| word_left_i | input | 1 | 1: sample at top of word, 0: at bottom |
| ext_mode_i | input | 2 | Fill for right-aligned word: 0 zero, 1 sign, 2 ones, 3 zero |
| rx_valid_i | input | 1 | Receive slot bits valid |
| rx_slot_i | input | 32 | Raw slot bits from the shifter |
| rx_valid_o | output | 1 | Receive word valid |
| rx_word_o | output | 32 | Formatted word for the holding register |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_word_i | input | 32 | Word written by the host |
| tx_valid_o | output | 1 | Transmit slot bits valid |
| tx_slot_o | output | 32 | Slot bits for the shifter |

## Verification
The bench drives a data code larger than the slot code. A design that fails to clamp the sample width would pull stray bus bits above the slot into the word, or shift the sample by the wrong amount. Mirroring is combined with sign extension, so a design that mirrors after filling, or takes the sign from the unmirrored sample, returns the wrong upper bits. Extension is also driven on left-aligned words, where a design that leaks fill below the sample fails the check. Round trips through both paths, together with idle gaps between valid beats, expose paths that are not exact inverses and outputs that drift while no input is valid.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam int STEP_W    = 8;
  localparam int NUM_SIZES = 4;
  localparam int WORD_W    = STEP_W * NUM_SIZES;

  typedef enum logic [1:0] {
    EXT_ZERO = 2'd0,
    EXT_SIGN = 2'd1,
    EXT_ONES = 2'd2,
    EXT_RSVD = 2'd3
  } ext_mode_e;
endpackage

// File: rtl/fmt_bit_rev.sv
module fmt_bit_rev #(
  parameter int W  = 32,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  data_i,
  input  logic [LW-1:0] len_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] flip;

  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flip[i] = data_i[W-1-i];
  end

  // input is zero above len_i, so the mirrored sample lands at the top; move it down
  assign data_o = flip >> (LW'(W) - len_i);
endmodule

// File: rtl/fmt_rx_path.sv
module fmt_rx_path #(
  parameter int W  = 32,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [LW-1:0]         slot_len_i,
  input  logic [LW-1:0]         data_len_i,
  input  logic                  slot_left_i,
  input  logic                  bit_rev_i,
  input  logic                  word_left_i,
  input  fmt_pkg::ext_mode_e    ext_mode_i,
  input  logic [W-1:0]          slot_i,
  output logic [W-1:0]          word_o
);
  logic [W-1:0] ones, slot_mask, data_mask, slot_m, raw, rev, samp, fill, sgn_sh;

  assign ones      = '1;
  assign slot_mask = ones >> (LW'(W) - slot_len_i);
  assign data_mask = ones >> (LW'(W) - data_len_i);
  assign slot_m    = slot_i & slot_mask;
  assign raw       = (slot_left_i ? (slot_m >> (slot_len_i - data_len_i)) : slot_m) & data_mask;

  fmt_bit_rev #(.W(W), .LW(LW)) u_rev (
    .data_i (raw),
    .len_i  (data_len_i),
    .data_o (rev)
  );

  assign samp   = bit_rev_i ? rev : raw;
  assign sgn_sh = samp >> (data_len_i - LW'(1));

  always_comb begin
    unique case (ext_mode_i)
      fmt_pkg::EXT_SIGN: fill = {W{sgn_sh[0]}};
      fmt_pkg::EXT_ONES: fill = ones;
      default:           fill = '0;
    endcase
  end

  assign word_o = word_left_i ? (samp << (LW'(W) - data_len_i))
                              : (samp | (fill & ~data_mask));
endmodule

// File: rtl/fmt_tx_path.sv
module fmt_tx_path #(
  parameter int W  = 32,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [LW-1:0] slot_len_i,
  input  logic [LW-1:0] data_len_i,
  input  logic          slot_left_i,
  input  logic          bit_rev_i,
  input  logic          word_left_i,
  input  logic [W-1:0]  word_i,
  output logic [W-1:0]  slot_o
);
  logic [W-1:0] ones, data_mask, raw, rev, samp;

  assign ones      = '1;
  assign data_mask = ones >> (LW'(W) - data_len_i);
  assign raw       = word_left_i ? (word_i >> (LW'(W) - data_len_i)) : (word_i & data_mask);

  fmt_bit_rev #(.W(W), .LW(LW)) u_rev (
    .data_i (raw),
    .len_i  (data_len_i),
    .data_o (rev)
  );

  assign samp   = bit_rev_i ? rev : raw;
  assign slot_o = slot_left_i ? (samp << (slot_len_i - data_len_i)) : samp;
endmodule

// File: rtl/audio_fmt.sv
module audio_fmt #(
  parameter  int STEP_W    = fmt_pkg::STEP_W,
  parameter  int NUM_SIZES = fmt_pkg::NUM_SIZES,
  localparam int WORD_W    = STEP_W * NUM_SIZES,
  localparam int SIZE_W    = $clog2(NUM_SIZES),
  localparam int LEN_W     = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIZE_W-1:0] slot_size_i,
  input  logic [SIZE_W-1:0] data_size_i,
  input  logic              slot_left_i,
  input  logic              bit_rev_i,
  input  logic              word_left_i,
  input  logic [1:0]        ext_mode_i,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_slot_i,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_word_o,
  input  logic              tx_valid_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_valid_o,
  output logic [WORD_W-1:0] tx_slot_o
);
  import fmt_pkg::*;

  logic [LEN_W-1:0]  slot_len, data_len_raw, data_len;
  logic [WORD_W-1:0] rx_word_c, tx_slot_c;
  ext_mode_e         ext_mode;

  assign ext_mode     = ext_mode_e'(ext_mode_i);
  assign slot_len     = LEN_W'((int'(slot_size_i) + 1) * STEP_W);
  assign data_len_raw = LEN_W'((int'(data_size_i) + 1) * STEP_W);
  assign data_len     = (data_len_raw > slot_len) ? slot_len : data_len_raw;

  fmt_rx_path #(.W(WORD_W), .LW(LEN_W)) u_rx (
    .slot_len_i  (slot_len),
    .data_len_i  (data_len),
    .slot_left_i (slot_left_i),
    .bit_rev_i   (bit_rev_i),
    .word_left_i (word_left_i),
    .ext_mode_i  (ext_mode),
    .slot_i      (rx_slot_i),
    .word_o      (rx_word_c)
  );

  fmt_tx_path #(.W(WORD_W), .LW(LEN_W)) u_tx (
    .slot_len_i  (slot_len),
    .data_len_i  (data_len),
    .slot_left_i (slot_left_i),
    .bit_rev_i   (bit_rev_i),
    .word_left_i (word_left_i),
    .word_i      (tx_word_i),
    .slot_o      (tx_slot_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o <= 1'b0;
      rx_word_o  <= '0;
      tx_valid_o <= 1'b0;
      tx_slot_o  <= '0;
    end else begin
      rx_valid_o <= rx_valid_i;
      tx_valid_o <= tx_valid_i;
      if (rx_valid_i) rx_word_o <= rx_word_c;
      if (tx_valid_i) tx_slot_o <= tx_slot_c;
    end
  end

  // Masks used only by the checks below
  logic [WORD_W-1:0] all_ones, data_mask_c, lo_pad_c, occ_mask_c;
  assign all_ones    = '1;
  assign data_mask_c = all_ones >> (LEN_W'(WORD_W) - data_len);
  assign lo_pad_c    = all_ones >> data_len;
  assign occ_mask_c  = slot_left_i ? (data_mask_c << (slot_len - data_len)) : data_mask_c;

  assert_rx_left_pad_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && word_left_i |=> (rx_word_o & $past(lo_pad_c)) == '0);

  assert_rx_zero_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !word_left_i && (ext_mode == EXT_ZERO || ext_mode == EXT_RSVD)
    |=> (rx_word_o & ~$past(data_mask_c)) == '0);

  assert_rx_sign_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !word_left_i && ext_mode == EXT_SIGN
    |=> (rx_word_o & ~$past(data_mask_c)) ==
        (((rx_word_o >> ($past(data_len) - LEN_W'(1))) & WORD_W'(1)) != '0
          ? ~$past(data_mask_c) : '0));

  assert_rx_ones_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !word_left_i && ext_mode == EXT_ONES |=> &(rx_word_o | $past(data_mask_c)));

  assert_tx_slot_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> (tx_slot_o & ~$past(occ_mask_c)) == '0);

  assert_rx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(rx_word_o) && !rx_valid_o);

  assert_tx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_i |=> $stable(tx_slot_o) && !tx_valid_o);
endmodule

// File: tb/audio_fmt_tb.sv
module audio_fmt_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  slot_size, data_size, ext_mode;
  logic        slot_left, bit_rev, word_left;
  logic        rx_valid_i, tx_valid_i, rx_valid_o, tx_valid_o;
  logic [31:0] rx_slot, rx_word, tx_word, tx_slot;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t rx_q[$];
  item_t tx_q[$];
  item_t it;
  logic [31:0] last_rx = '0;
  logic [31:0] last_tx = '0;

  always #5 clk = ~clk;

  audio_fmt u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .slot_size_i (slot_size),
    .data_size_i (data_size),
    .slot_left_i (slot_left),
    .bit_rev_i   (bit_rev),
    .word_left_i (word_left),
    .ext_mode_i  (ext_mode),
    .rx_valid_i  (rx_valid_i),
    .rx_slot_i   (rx_slot),
    .rx_valid_o  (rx_valid_o),
    .rx_word_o   (rx_word),
    .tx_valid_i  (tx_valid_i),
    .tx_word_i   (tx_word),
    .tx_valid_o  (tx_valid_o),
    .tx_slot_o   (tx_slot)
  );

  function automatic int eff_dw(int ss, int ds);
    int sw, dw;
    sw = 8 * (ss + 1);
    dw = 8 * (ds + 1);
    return (dw > sw) ? sw : dw;
  endfunction

  function automatic logic [31:0] rx_ref(int ss, int ds, bit sl, bit rv, bit wl, int ext,
                                         logic [31:0] s);
    int sw, dw;
    logic [31:0] smp, r, w;
    sw = 8 * (ss + 1);
    dw = eff_dw(ss, ds);
    smp = '0; r = '0; w = '0;
    for (int i = 0; i < dw; i++) smp[i] = sl ? s[sw - dw + i] : s[i];
    for (int i = 0; i < dw; i++) r[i] = rv ? smp[dw - 1 - i] : smp[i];
    if (wl) begin
      for (int i = 0; i < dw; i++) w[32 - dw + i] = r[i];
    end else begin
      for (int i = 0; i < 32; i++) begin
        if (i < dw)        w[i] = r[i];
        else if (ext == 1) w[i] = r[dw - 1];
        else if (ext == 2) w[i] = 1'b1;
        else               w[i] = 1'b0;
      end
    end
    return w;
  endfunction

  function automatic logic [31:0] tx_ref(int ss, int ds, bit sl, bit rv, bit wl,
                                         logic [31:0] w);
    int sw, dw;
    logic [31:0] smp, r, s;
    sw = 8 * (ss + 1);
    dw = eff_dw(ss, ds);
    smp = '0; r = '0; s = '0;
    for (int i = 0; i < dw; i++) smp[i] = wl ? w[32 - dw + i] : w[i];
    for (int i = 0; i < dw; i++) r[i] = rv ? smp[dw - 1 - i] : smp[i];
    for (int i = 0; i < dw; i++) s[(sl ? sw - dw : 0) + i] = r[i];
    return s;
  endfunction

  function automatic logic [31:0] occ_ref(int ss, int ds, bit sl);
    int sw, dw;
    logic [31:0] m;
    sw = 8 * (ss + 1);
    dw = eff_dw(ss, ds);
    m = '0;
    for (int i = 0; i < dw; i++) m[(sl ? sw - dw : 0) + i] = 1'b1;
    return m;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply(int ss, int ds, bit sl, bit rv, bit wl, int ext,
                       logic [31:0] s, logic [31:0] w, bit rxv, bit txv, string tag);
    item_t x;
    @(negedge clk);
    slot_size  = 2'(ss);
    data_size  = 2'(ds);
    slot_left  = sl;
    bit_rev    = rv;
    word_left  = wl;
    ext_mode   = 2'(ext);
    rx_slot    = s;
    tx_word    = w;
    rx_valid_i = rxv;
    tx_valid_i = txv;
    if (rxv) begin
      x.exp = rx_ref(ss, ds, sl, rv, wl, ext, s);
      x.tag = tag;
      rx_q.push_back(x);
    end
    if (txv) begin
      x.exp = tx_ref(ss, ds, sl, rv, wl, w);
      x.tag = tag;
      tx_q.push_back(x);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid_i = 1'b0;
      tx_valid_i = 1'b0;
      rx_slot    = $urandom();
      tx_word    = $urandom();
    end
  endtask

  task automatic round_trip(int ss, int ds, bit sl, bit rv, bit wl, int ext, logic [31:0] s);
    logic [31:0] w;
    apply(ss, ds, sl, rv, wl, ext, s, '0, 1'b1, 1'b0, "R9");
    @(posedge clk); #2;
    w = rx_word;
    apply(ss, ds, sl, rv, wl, ext, '0, w, 1'b0, 1'b1, "R9");
    @(posedge clk); #2;
    chk(tx_slot == (s & occ_ref(ss, ds, sl)), "R9 round trip", tx_slot, s & occ_ref(ss, ds, sl));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitor: compare registered outputs one step after each edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (rx_valid_o) begin
        if (rx_q.size() == 0) chk(1'b0, "R10 rx valid without input", rx_word, '0);
        else begin
          it = rx_q.pop_front();
          chk(rx_word == it.exp, it.tag, rx_word, it.exp);
        end
        last_rx = rx_word;
      end else chk(rx_word == last_rx, "R10 rx hold", rx_word, last_rx);
      if (tx_valid_o) begin
        if (tx_q.size() == 0) chk(1'b0, "R10 tx valid without input", tx_slot, '0);
        else begin
          it = tx_q.pop_front();
          chk(tx_slot == it.exp, it.tag, tx_slot, it.exp);
        end
        last_tx = tx_slot;
      end else chk(tx_slot == last_tx, "R10 tx hold", tx_slot, last_tx);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 act=hung exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    slot_size = '0; data_size = '0; ext_mode = '0;
    slot_left = 1'b0; bit_rev = 1'b0; word_left = 1'b0;
    rx_valid_i = 1'b0; tx_valid_i = 1'b0;
    rx_slot = 32'hFFFF_FFFF; tx_word = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #2;
    chk(rx_word == '0 && !rx_valid_o, "R10 reset rx", rx_word, '0);
    chk(tx_slot == '0 && !tx_valid_o, "R10 reset tx", tx_slot, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: data code above slot code clamps to slot width; bus bits above slot ignored
    apply(0, 3, 0, 0, 0, 0, 32'hFFFF_FFA5, 32'h1234_56C3, 1, 1, "R1 clamp 8/32");
    apply(1, 2, 1, 0, 0, 0, 32'hABCD_5A3C, 32'h0000_9876, 1, 1, "R1 clamp 16/24");
    // R2: slot alignment
    apply(3, 1, 1, 0, 0, 0, 32'h1234_5678, '0, 1, 0, "R2 slot left");
    apply(3, 1, 0, 0, 0, 0, 32'h1234_5678, '0, 1, 0, "R2 slot right");
    apply(2, 0, 1, 0, 0, 0, 32'hFF12_3456, '0, 1, 0, "R2 slot left 24/8");
    idle(2);
    // R3: mirroring, alone and under sign fill
    apply(1, 0, 0, 1, 0, 0, 32'h0000_0001, 32'h0000_0080, 1, 1, "R3 rev zero fill");
    apply(1, 0, 0, 1, 0, 1, 32'h0000_0001, 32'h0000_0001, 1, 1, "R3 R6 rev sign");
    apply(3, 2, 1, 1, 1, 2, 32'h8000_0100, 32'h0100_0080, 1, 1, "R3 rev left word");
    // R4: left word, fill never leaks below
    apply(3, 2, 1, 0, 1, 2, 32'hABCD_EF12, '0, 1, 0, "R4 left word ones");
    apply(3, 0, 0, 0, 1, 1, 32'h0000_0080, '0, 1, 0, "R4 left word sign");
    idle(1);
    // R5 R6 R7: extension modes
    apply(3, 1, 0, 0, 0, 0, 32'h0000_8001, '0, 1, 0, "R5 zero fill");
    apply(3, 1, 0, 0, 0, 1, 32'h0000_8001, '0, 1, 0, "R6 sign neg");
    apply(3, 1, 0, 0, 0, 1, 32'h0000_7001, '0, 1, 0, "R6 sign pos");
    apply(3, 1, 0, 0, 0, 2, 32'h0000_7001, '0, 1, 0, "R7 ones");
    apply(3, 1, 0, 0, 0, 3, 32'h0000_F001, '0, 1, 0, "R7 code3 zero");
    apply(3, 3, 0, 0, 0, 2, 32'h8000_0000, '0, 1, 0, "R7 full width");
    // R8: transmit placement
    apply(2, 1, 1, 0, 0, 0, '0, 32'hDEAD_BEEF, 0, 1, "R8 tx slot left");
    apply(2, 1, 0, 0, 1, 0, '0, 32'hDEAD_BEEF, 0, 1, "R8 tx word left");
    apply(0, 0, 1, 1, 1, 0, '0, 32'hC300_00FF, 0, 1, "R8 tx 8 rev");
    idle(3);

    // R9: round trips
    for (int k = 0; k < 40; k++)
      round_trip($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom()), 1'($urandom()),
                 1'($urandom()), $urandom_range(0, 3), $urandom());
    idle(2);

    // Random mix with gaps (R1 R10)
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else apply($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom()), 1'($urandom()),
                 1'($urandom()), $urandom_range(0, 3), $urandom(), $urandom(),
                 1'($urandom()), 1'($urandom()), "R1 R10 random");
    end
    idle(3);
    chk(rx_q.size() == 0, "R10 rx drained", 32'(rx_q.size()), '0);
    chk(tx_q.size() == 0, "R10 tx drained", 32'(tx_q.size()), '0);
    finish_run();
  end
endmodule